// File: doc/BRIEF.md
# Processor Exception Control Unit

This unit holds the trap-related control state of a small 32-bit soft processor and chooses where execution resumes when a trap is raised or a handler returns. The pipeline presents one-cycle trap requests (breakpoint, system call, data bus error, divide by zero) together with the PC of the faulting instruction. The unit then issues a one-cycle redirect carrying the handler address. That address is formed from one of two aligned base registers, with each exception ID owning a 32-byte slot.

The interrupt-enable register has three bits. Bit 0 is the live global enable, bit 1 is the copy saved by ordinary exceptions, and bit 2 is the copy saved by breakpoints. Return strobes restore bit 0 from the matching copy and redirect to the saved return address. A pending-interrupt register collects set pulses from the interrupt sources, and software clears it by writing ones. The unit also gates the write-back enable of an unsigned divide or modulo, so that a zero divisor traps instead of writing a result.

Top module: `exc_ctrl_unit`

## Requirements
- R1: When an ordinary exception (data bus error, divide by zero, system call) is taken, the interrupt-enable register becomes {bit2=0, bit1=old bit0, bit0=0}.
- R2: When a breakpoint is taken, the interrupt-enable register becomes {bit2=old bit0, bit1=0, bit0=0}.
- R3: The redirect target of a trap is the base register OR (ID × 32). Ordinary exceptions use the exception base, and a breakpoint (ID 1) uses the debug base. The IDs are data bus error 4, divide by zero 5 and system call 7.
- R4: The faulting PC is stored in the exception return register for ordinary exceptions and in the breakpoint return register for breakpoints. The new value is visible on the outputs one cycle after the request.
- R5: A return-from-exception strobe redirects to the exception return register and sets the enable register to {0,0,old bit1}. A return-from-breakpoint strobe redirects to the breakpoint return register and sets it to {0,0,old bit2}. A trap beats both strobes, and return-from-exception beats return-from-breakpoint.
- R6: The redirect valid output is high for exactly the one cycle following a cycle with a taken trap or return strobe, and is low otherwise.
- R7: When several trap requests arrive in the same cycle, the lowest ID wins, and only that trap's state is updated.
- R8: Each cycle the set inputs are ORed into the pending register. A CSR write to select 1 clears every pending bit written as 1 and leaves bits written as 0 unchanged. A set and a clear of the same bit in one cycle leaves the bit set.
- R9: CSR writes replace the addressed register: select 0 is the enable register (bits 2:0), 2 the exception base, 3 the debug base, 4 the exception return and 5 the breakpoint return. Base writes force bits 7:0 to zero, selects 6 and 7 have no effect, and any CSR write in a cycle that takes a trap or return strobe is dropped.
- R10: A divide issue with a zero divisor raises divide by zero and holds the write-back enable low in the same cycle. A non-zero divisor raises the write-back enable and does not trap.
- R11: An unmapped access and a misaligned access each raise the data bus error exception (ID 4).
- R12: After reset, the enable register, both bases, both return registers and the pending register are zero, and no redirect is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| brk_req_i | input | 1 | Breakpoint trap request |
| scall_req_i | input | 1 | System call trap request |
| dbus_unmapped_i | input | 1 | Data access to an unmapped address |
| dbus_misalign_i | input | 1 | Misaligned data access |
| div_issue_i | input | 1 | Unsigned divide or modulo issued this cycle |
| div_divisor_i | input | XLEN | Divisor operand of the issued divide |
| fault_pc_i | input | XLEN | PC of the instruction raising a trap |
| eret_i | input | 1 | Return-from-exception strobe |
| bret_i | input | 1 | Return-from-breakpoint strobe |
| csr_we_i | input | 1 | CSR write enable |
| csr_sel_i | input | 3 | CSR select |
| csr_wdata_i | input | XLEN | CSR write data |
| irq_set_i | input | NIRQ | Pending-interrupt set pulses |
| redir_valid_o | output | 1 | One-cycle redirect pulse |
| redir_pc_o | output | XLEN | Redirect target address |
| eaddr_o | output | XLEN | Exception return address |
| baddr_o | output | XLEN | Breakpoint return address |
| gie_o | output | 1 | Global interrupt enable (enable bit 0) |
| irq_pend_o | output | NIRQ | Pending-interrupt register |
| div_wb_en_o | output | 1 | Divide result write-back enable |

## Verification
The directed part first programs both bases with dirty low bytes, then walks through single traps of each kind, each followed by its matching return. This shows whether the right base, slot, return register and enable copy are used. It also shows that an unmapped access and a misaligned access land in the same slot. Simultaneous requests (breakpoint with system call) and strobes colliding with CSR writes tell the priority order apart from plain OR-ing. A set and a clear of the same pending bit in one cycle separates set-wins from clear-wins. A long random phase then mixes every request, strobe and CSR select against a bench model, which exposes ordering faults between the update paths.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int unsigned EXC_ID_W = 3;
   localparam int unsigned EXC_NUM  = 1 << EXC_ID_W;

   typedef enum logic [EXC_ID_W-1:0] {
      EXC_RESET = 3'd0,
      EXC_BREAK = 3'd1,
      EXC_IBUS  = 3'd2,
      EXC_WATCH = 3'd3,
      EXC_DBUS  = 3'd4,
      EXC_DIV0  = 3'd5,
      EXC_IRQ   = 3'd6,
      EXC_SCALL = 3'd7
   } exc_id_e;

   localparam int unsigned CSR_SEL_W = 3;

   typedef enum logic [CSR_SEL_W-1:0] {
      CSR_IE    = 3'd0,
      CSR_IP    = 3'd1,
      CSR_EBASE = 3'd2,
      CSR_DBASE = 3'd3,
      CSR_EADDR = 3'd4,
      CSR_BADDR = 3'd5
   } csr_sel_e;

endpackage

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
   parameter int unsigned N   = 8,
   parameter int unsigned IDW = 3
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [N-1:0]   req_i,
   output logic           valid_o,
   output logic [IDW-1:0] id_o
);

   logic [N-1:0] grant;

   // lower index masks all higher ones
   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_grant
         if (gi == 0) begin : g_first
            assign grant[gi] = req_i[gi];
         end else begin : g_rest
            assign grant[gi] = req_i[gi] & ~(|req_i[gi-1:0]);
         end
      end
   endgenerate

   always_comb begin
      id_o = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) id_o = id_o | IDW'(i);
      end
   end

   assign valid_o = |req_i;

   assert_grant_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant));
   assert_grant_in_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant & ~req_i) == '0);
   assert_grant_present_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $countones(grant) == 1);

endmodule

// File: rtl/exc_csr_file.sv
module exc_csr_file
   import exc_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned NIRQ      = 8,
   parameter int unsigned ALIGN_LSB = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 take_exc_i,
   input  logic                 take_brk_i,
   input  logic                 take_eret_i,
   input  logic                 take_bret_i,
   input  logic [XLEN-1:0]      fault_pc_i,
   input  logic                 csr_we_i,
   input  logic [CSR_SEL_W-1:0] csr_sel_i,
   input  logic [XLEN-1:0]      csr_wdata_i,
   input  logic [NIRQ-1:0]      irq_set_i,
   output logic                 gie_o,
   output logic [NIRQ-1:0]      ip_o,
   output logic [XLEN-1:0]      ebase_o,
   output logic [XLEN-1:0]      dbase_o,
   output logic [XLEN-1:0]      eaddr_o,
   output logic [XLEN-1:0]      baddr_o
);

   logic [2:0]      ie_q;
   logic [NIRQ-1:0] ip_q;
   logic [XLEN-1:0] ebase_q, dbase_q, eaddr_q, baddr_q;
   logic            flow, wr_ok;
   logic [NIRQ-1:0] ip_clr;
   logic [XLEN-1:0] base_wdata;

   assign flow       = take_exc_i | take_brk_i | take_eret_i | take_bret_i;
   assign wr_ok      = csr_we_i & ~flow;
   assign ip_clr     = (wr_ok && csr_sel_i == CSR_IP) ? csr_wdata_i[NIRQ-1:0] : '0;
   assign base_wdata = {csr_wdata_i[XLEN-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ie_q <= '0;
      end else if (take_brk_i) begin
         ie_q <= {ie_q[0], 2'b00};
      end else if (take_exc_i) begin
         ie_q <= {1'b0, ie_q[0], 1'b0};
      end else if (take_eret_i) begin
         ie_q <= {2'b00, ie_q[1]};
      end else if (take_bret_i) begin
         ie_q <= {2'b00, ie_q[2]};
      end else if (wr_ok && csr_sel_i == CSR_IE) begin
         ie_q <= csr_wdata_i[2:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         eaddr_q <= '0;
         baddr_q <= '0;
      end else begin
         if (take_exc_i)                          eaddr_q <= fault_pc_i;
         else if (wr_ok && csr_sel_i == CSR_EADDR) eaddr_q <= csr_wdata_i;
         if (take_brk_i)                          baddr_q <= fault_pc_i;
         else if (wr_ok && csr_sel_i == CSR_BADDR) baddr_q <= csr_wdata_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ebase_q <= '0;
         dbase_q <= '0;
         ip_q    <= '0;
      end else begin
         if (wr_ok && csr_sel_i == CSR_EBASE) ebase_q <= base_wdata;
         if (wr_ok && csr_sel_i == CSR_DBASE) dbase_q <= base_wdata;
         ip_q <= (ip_q & ~ip_clr) | irq_set_i;
      end
   end

   assign gie_o   = ie_q[0];
   assign ip_o    = ip_q;
   assign ebase_o = ebase_q;
   assign dbase_o = dbase_q;
   assign eaddr_o = eaddr_q;
   assign baddr_o = baddr_q;

   assert_exc_ie_save_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_exc_i |=> ie_q == {1'b0, $past(ie_q[0]), 1'b0});
   assert_brk_ie_save_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_brk_i |=> ie_q == {$past(ie_q[0]), 2'b00});
   assert_ip_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_set_i == '0 && !(csr_we_i && csr_sel_i == CSR_IP)) |=> $stable(ip_q));
   assert_exc_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(take_exc_i && take_brk_i));

endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
   import exc_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned IDW     = 3,
   parameter int unsigned SLOT_SH = 5
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            trap_v_i,
   input  logic [IDW-1:0]  trap_id_i,
   input  logic            eret_i,
   input  logic            bret_i,
   input  logic [XLEN-1:0] ebase_i,
   input  logic [XLEN-1:0] dbase_i,
   input  logic [XLEN-1:0] eaddr_i,
   input  logic [XLEN-1:0] baddr_i,
   output logic            redir_v_o,
   output logic [XLEN-1:0] redir_pc_o
);

   localparam int unsigned PAD_W = XLEN - IDW - SLOT_SH;

   logic [XLEN-1:0] slot_off, trap_tgt, next_pc;
   logic            next_v;

   assign slot_off = {{PAD_W{1'b0}}, trap_id_i, {SLOT_SH{1'b0}}};
   assign trap_tgt = ((trap_id_i == EXC_BREAK) ? dbase_i : ebase_i) | slot_off;

   always_comb begin
      next_v  = 1'b1;
      next_pc = trap_tgt;
      if (!trap_v_i) begin
         if (eret_i)      next_pc = eaddr_i;
         else if (bret_i) next_pc = baddr_i;
         else             next_v  = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         redir_v_o  <= 1'b0;
         redir_pc_o <= '0;
      end else begin
         redir_v_o <= next_v;
         if (next_v) redir_pc_o <= next_pc;
      end
   end

   assert_redir_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_v_i || eret_i || bret_i) |=> redir_v_o);
   assert_redir_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(trap_v_i || eret_i || bret_i) |=> !redir_v_o);
   assert_eret_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eret_i && !trap_v_i) |=> redir_pc_o == $past(eaddr_i));

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
   import exc_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned NIRQ       = 8,
   parameter int unsigned SLOT_BYTES = 32
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 brk_req_i,
   input  logic                 scall_req_i,
   input  logic                 dbus_unmapped_i,
   input  logic                 dbus_misalign_i,
   input  logic                 div_issue_i,
   input  logic [XLEN-1:0]      div_divisor_i,
   input  logic [XLEN-1:0]      fault_pc_i,
   input  logic                 eret_i,
   input  logic                 bret_i,
   input  logic                 csr_we_i,
   input  logic [CSR_SEL_W-1:0] csr_sel_i,
   input  logic [XLEN-1:0]      csr_wdata_i,
   input  logic [NIRQ-1:0]      irq_set_i,
   output logic                 redir_valid_o,
   output logic [XLEN-1:0]      redir_pc_o,
   output logic [XLEN-1:0]      eaddr_o,
   output logic [XLEN-1:0]      baddr_o,
   output logic                 gie_o,
   output logic [NIRQ-1:0]      irq_pend_o,
   output logic                 div_wb_en_o
);

   localparam int unsigned SLOT_SH   = $clog2(SLOT_BYTES);
   localparam int unsigned ALIGN_LSB = SLOT_SH + EXC_ID_W;

   generate
      if ((1 << SLOT_SH) != SLOT_BYTES) begin : g_bad_slot
         $error("SLOT_BYTES must be a power of two");
      end
      if (ALIGN_LSB >= XLEN) begin : g_bad_align
         $error("handler table does not fit in XLEN");
      end
      if (NIRQ > XLEN || NIRQ < 1) begin : g_bad_irq
         $error("NIRQ must lie in 1..XLEN");
      end
   endgenerate

   logic [EXC_NUM-1:0]  req;
   logic                trap_v;
   logic [EXC_ID_W-1:0] trap_id;
   logic                div_zero;
   logic                take_brk, take_exc, take_eret, take_bret;
   logic [XLEN-1:0]     ebase, dbase;

   assign div_zero    = div_issue_i & ~(|div_divisor_i);
   assign div_wb_en_o = div_issue_i & ~div_zero;

   always_comb begin
      req                 = '0;
      req[int'(EXC_BREAK)] = brk_req_i;
      req[int'(EXC_DBUS)]  = dbus_unmapped_i | dbus_misalign_i;
      req[int'(EXC_DIV0)]  = div_zero;
      req[int'(EXC_SCALL)] = scall_req_i;
   end

   exc_prio_enc #(.N(EXC_NUM), .IDW(EXC_ID_W)) u_prio (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req),
      .valid_o (trap_v),
      .id_o    (trap_id)
   );

   assign take_brk  = trap_v & (trap_id == EXC_BREAK);
   assign take_exc  = trap_v & ~take_brk;
   assign take_eret = eret_i & ~trap_v;
   assign take_bret = bret_i & ~trap_v & ~eret_i;

   exc_csr_file #(.XLEN(XLEN), .NIRQ(NIRQ), .ALIGN_LSB(ALIGN_LSB)) u_csr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .take_exc_i  (take_exc),
      .take_brk_i  (take_brk),
      .take_eret_i (take_eret),
      .take_bret_i (take_bret),
      .fault_pc_i  (fault_pc_i),
      .csr_we_i    (csr_we_i),
      .csr_sel_i   (csr_sel_i),
      .csr_wdata_i (csr_wdata_i),
      .irq_set_i   (irq_set_i),
      .gie_o       (gie_o),
      .ip_o        (irq_pend_o),
      .ebase_o     (ebase),
      .dbase_o     (dbase),
      .eaddr_o     (eaddr_o),
      .baddr_o     (baddr_o)
   );

   exc_redirect #(.XLEN(XLEN), .IDW(EXC_ID_W), .SLOT_SH(SLOT_SH)) u_redir (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .trap_v_i   (trap_v),
      .trap_id_i  (trap_id),
      .eret_i     (take_eret),
      .bret_i     (take_bret),
      .ebase_i    (ebase),
      .dbase_i    (dbase),
      .eaddr_i    (eaddr_o),
      .baddr_i    (baddr_o),
      .redir_v_o  (redir_valid_o),
      .redir_pc_o (redir_pc_o)
   );

   assert_div_zero_nowb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_issue_i && div_divisor_i == '0) |-> !div_wb_en_o);
   assert_dbus_target_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((dbus_unmapped_i || dbus_misalign_i) && !brk_req_i) |=> redir_valid_o && redir_pc_o[ALIGN_LSB-1:0] == ALIGN_LSB'(int'(EXC_DBUS) << SLOT_SH));
   assert_fault_pc_saved_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (brk_req_i) |=> baddr_o == $past(fault_pc_i));

endmodule

// File: tb/test_exc_ctrl_unit.sv
module test_exc_ctrl_unit;

   localparam int XLEN = 32;
   localparam int NIRQ = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            brk, scall, unm, mis, div_iss, eret, bret, csr_we;
   logic [XLEN-1:0] divisor, fpc, wdata;
   logic [2:0]      sel;
   logic [NIRQ-1:0] irq_set;
   logic            redir_v, gie, wb_en;
   logic [XLEN-1:0] redir_pc, ea, ba;
   logic [NIRQ-1:0] ip;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // bench model
   logic [2:0]      m_ie;
   logic [NIRQ-1:0] m_ip;
   logic [XLEN-1:0] m_eba, m_deba, m_ea, m_ba, m_rpc;
   logic            m_rv;

   always #10 clk = ~clk;

   exc_ctrl_unit #(.XLEN(XLEN), .NIRQ(NIRQ), .SLOT_BYTES(32)) i_exc_ctrl_unit (
      .clk_i(clk), .rst_ni(rst_n), .brk_req_i(brk), .scall_req_i(scall),
      .dbus_unmapped_i(unm), .dbus_misalign_i(mis), .div_issue_i(div_iss),
      .div_divisor_i(divisor), .fault_pc_i(fpc), .eret_i(eret), .bret_i(bret),
      .csr_we_i(csr_we), .csr_sel_i(sel), .csr_wdata_i(wdata), .irq_set_i(irq_set),
      .redir_valid_o(redir_v), .redir_pc_o(redir_pc), .eaddr_o(ea), .baddr_o(ba),
      .gie_o(gie), .irq_pend_o(ip), .div_wb_en_o(wb_en)
   );

   task automatic chk(input bit ok, input string req, input string ctx,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, ctx, act, exp);
      end
   endtask

   task automatic idle();
      brk = 0; scall = 0; unm = 0; mis = 0; div_iss = 0; divisor = '0;
      fpc = '0; eret = 0; bret = 0; csr_we = 0; sel = '0; wdata = '0; irq_set = '0;
   endtask

   function automatic logic [XLEN-1:0] align_base(input logic [XLEN-1:0] v);
      return {v[XLEN-1:8], 8'h00};
   endfunction

   // advance model by one clock using the currently driven inputs
   task automatic model_next();
      logic       d0, db, tv;
      logic [2:0] id;
      logic       flow;
      logic [NIRQ-1:0] clr;
      d0 = div_iss && (divisor == '0);
      db = unm | mis;
      tv = brk | db | d0 | scall;
      id = brk ? 3'd1 : db ? 3'd4 : d0 ? 3'd5 : 3'd7;
      flow = tv | eret | bret;
      clr = '0;
      m_rv = flow;
      if (tv) begin
         m_rpc = ((id == 3'd1) ? m_deba : m_eba) | (XLEN'(id) << 5);
         if (id == 3'd1) begin m_ba = fpc; m_ie = {m_ie[0], 2'b00}; end
         else            begin m_ea = fpc; m_ie = {1'b0, m_ie[0], 1'b0}; end
      end else if (eret) begin
         m_rpc = m_ea; m_ie = {2'b00, m_ie[1]};
      end else if (bret) begin
         m_rpc = m_ba; m_ie = {2'b00, m_ie[2]};
      end else if (csr_we) begin
         case (sel)
            3'd0: m_ie   = wdata[2:0];
            3'd1: clr    = wdata[NIRQ-1:0];
            3'd2: m_eba  = align_base(wdata);
            3'd3: m_deba = align_base(wdata);
            3'd4: m_ea   = wdata;
            3'd5: m_ba   = wdata;
            default: ;
         endcase
      end
      m_ip = (m_ip & ~clr) | irq_set;
   endtask

   // called at a falling edge with inputs driven
   task automatic step(input string ctx);
      logic exp_wb;
      #1;
      exp_wb = div_iss && (divisor != '0);
      chk(wb_en === exp_wb, "R10", ctx, XLEN'(wb_en), XLEN'(exp_wb));
      model_next();
      @(posedge clk);
      @(negedge clk);
      chk(redir_v === m_rv, "R6", ctx, XLEN'(redir_v), XLEN'(m_rv));
      if (m_rv) chk(redir_pc === m_rpc, "R3", ctx, redir_pc, m_rpc);
      chk(ea === m_ea, "R4", ctx, ea, m_ea);
      chk(ba === m_ba, "R4", ctx, ba, m_ba);
      chk(gie === m_ie[0], "R1", ctx, XLEN'(gie), XLEN'(m_ie[0]));
      chk(ip === m_ip, "R8", ctx, XLEN'(ip), XLEN'(m_ip));
      idle();
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      idle();
      m_ie = '0; m_ip = '0; m_eba = '0; m_deba = '0; m_ea = '0; m_ba = '0;
      m_rv = 0; m_rpc = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      chk(redir_v === 1'b0, "R12", "reset redirect", XLEN'(redir_v), '0);
      chk(ea === '0 && ba === '0, "R12", "reset return regs", ea | ba, '0);
      chk(gie === 1'b0, "R12", "reset gie", XLEN'(gie), '0);
      chk(ip === '0, "R12", "reset pending", XLEN'(ip), '0);

      // R9 base writes with dirty low byte
      csr_we = 1; sel = 3'd2; wdata = 32'h1234_56FF; step("ebase write");
      csr_we = 1; sel = 3'd3; wdata = 32'hABCD_0011; step("dbase write");
      csr_we = 1; sel = 3'd0; wdata = 32'h1;         step("ie write");
      chk(gie === 1'b1, "R9", "ie write", XLEN'(gie), 32'h1);
      csr_we = 1; sel = 3'd6; wdata = 32'hFFFF_FFFF; step("unused select");
      chk(gie === 1'b1 && ea === '0, "R9", "select 6 no effect", ea, '0);

      // R10 / R1 divide by zero
      div_iss = 1; divisor = '0; fpc = 32'h100; step("div0");
      chk(redir_pc === 32'h1234_56A0, "R3", "div0 slot 5", redir_pc, 32'h1234_56A0);
      chk(gie === 1'b0 && ea === 32'h100, "R1", "div0 ie/ea", ea, 32'h100);
      eret = 1; step("eret");
      chk(redir_pc === 32'h100 && gie === 1'b1, "R5", "eret restores", redir_pc, 32'h100);
      div_iss = 1; divisor = 32'h3; fpc = 32'h104; step("div ok");
      chk(redir_v === 1'b0, "R10", "nonzero divisor no trap", XLEN'(redir_v), '0);

      // R7 breakpoint beats system call
      brk = 1; scall = 1; fpc = 32'h200; step("brk+scall");
      chk(redir_pc === 32'hABCD_0020, "R7", "lowest id wins", redir_pc, 32'hABCD_0020);
      chk(ea === 32'h100 && ba === 32'h200, "R7", "only brk state", ea, 32'h100);
      bret = 1; eret = 0; step("bret");
      chk(redir_pc === 32'h200 && gie === 1'b1, "R2", "bret restores bit2", redir_pc, 32'h200);
      eret = 1; bret = 1; step("eret+bret");
      chk(redir_pc === 32'h100, "R5", "eret beats bret", redir_pc, 32'h100);

      // R11 both data bus causes
      unm = 1; fpc = 32'h300; step("unmapped");
      chk(redir_pc === 32'h1234_5680, "R11", "unmapped slot 4", redir_pc, 32'h1234_5680);
      eret = 1; step("eret2");
      mis = 1; fpc = 32'h304; step("misaligned");
      chk(redir_pc === 32'h1234_5680, "R11", "misaligned slot 4", redir_pc, 32'h1234_5680);
      scall = 1; fpc = 32'h308; step("scall");
      chk(redir_pc === 32'h1234_56E0, "R3", "scall slot 7", redir_pc, 32'h1234_56E0);

      // R8 pending set / clear
      irq_set = 8'hA5; step("ip set");
      csr_we = 1; sel = 3'd1; wdata = 32'h0F; irq_set = 8'h01; step("ip clear");
      chk(ip === 8'hA1, "R8", "w1c with set wins", XLEN'(ip), 32'hA1);

      // R9 CSR write dropped during trap
      csr_we = 1; sel = 3'd4; wdata = 32'hDEAD; scall = 1; fpc = 32'h40C; step("csr vs trap");
      chk(ea === 32'h40C, "R9", "write dropped", ea, 32'h40C);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         brk     = ($urandom_range(0, 9) == 0);
         scall   = ($urandom_range(0, 9) == 0);
         unm     = ($urandom_range(0, 14) == 0);
         mis     = ($urandom_range(0, 14) == 0);
         div_iss = ($urandom_range(0, 5) == 0);
         divisor = ($urandom_range(0, 1) == 0) ? '0 : XLEN'($urandom);
         fpc     = XLEN'($urandom) & 32'hFFFF_FFFC;
         eret    = ($urandom_range(0, 7) == 0);
         bret    = ($urandom_range(0, 7) == 0);
         csr_we  = ($urandom_range(0, 2) == 0);
         sel     = 3'($urandom_range(0, 7));
         wdata   = XLEN'($urandom);
         irq_set = ($urandom_range(0, 3) == 0) ? NIRQ'($urandom) : '0;
         step("random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule